// File: doc/BRIEF.md
# Banked Exception Pending Controller

This block keeps the pending state of the system exceptions and external interrupts of a small processor core. Six system exceptions exist twice, once for the secure world and once for the non-secure world. All others have a single copy, which is held in the non-secure vector. Requests to set or clear pending state arrive from three sources in any cycle. The first is a register write port that carries a security attribute. The second is a request port driven by the core's internal fault logic. The third is a bank of level-sensitive interrupt lines. All requests that land in the same cycle are merged, and a set beats a clear on the same entry.

A synchronous fault that cannot be taken is pended as HardFault instead, and a shared forced-fault status bit is raised. A configuration input and the requester's security attribute choose which HardFault copy receives it. Enable and priority for each exception number come in on configuration inputs, and both copies of a banked exception use the same values. The block reports the best pending, enabled exception with its number and bank. It also brings out both pending vectors.

Top module: `bpc_pend_ctrl`

## Requirements
- R1: The banked numbers are 3, 4, 6, 11, 14 and 15. A set or clear request with the secure flag high updates the secure copy of such a number. A secure request for any other number is dropped, and req_err is high in the following cycle. With the flag low, a request updates the non-secure copy.
- R2: A request port target of 0, 1, or any number at or above NUM_EXC (16 + NUM_EXT) is dropped and raises req_err in the following cycle. Entries 0 and 1 are never pending.
- R3: A write to offset 0xD04 with data bit 31 set pends number 2 (NMI) in the non-secure copy, whatever the write's attribute.
- R4: In a 0xD04 write, bit 28 pends number 14 and bit 27 clears it. Bit 27 is ignored when bit 28 is also set. The bank is the write's security attribute.
- R5: In a 0xD04 write, bit 26 pends number 15 and bit 25 clears it. Bit 25 is ignored when bit 26 is also set. The bank is the write's security attribute.
- R6: A write to offset 0xF00 pends number data[8:0] + 16 in the non-secure copy. The write changes nothing when that sum is not below NUM_EXC.
- R7: A low-to-high change on irq_level[i] pends number 16 + i in the non-secure copy. A line held high does not pend it again after it is cleared.
- R8: A set request for numbers 4 to 13 is escalated when that number is disabled or its priority is numerically greater than or equal to run_prio. HardFault (3) is then pended in place of the original, and hf_forced goes high and stays high until reset.
- R9: An escalation pends the secure HardFault copy when HAS_SEC is 1 and either the request was secure or hf_ns_route is 0. In every other case it pends the non-secure copy.
- R10: A clear request removes only the addressed copy. Clearing an entry that is not pending leaves every output unchanged.
- R11: Reset clears both pending vectors, req_err and hf_forced.
- R12: The pending output names the best pending, enabled exception, one cycle after the request. Numbers 2 and 3 are always enabled and rank above every other number. The remaining numbers are ranked by lower priority value, then by lower number, then secure before non-secure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 12 | Register offset (0xD04 control-state, 0xF00 software trigger) |
| reg_wr_data | input | 32 | Register write data |
| reg_wr_secure | input | 1 | Security attribute of the write |
| req_valid | input | 1 | Fault request strobe |
| req_clear | input | 1 | 1 = clear pending, 0 = set pending |
| req_num | input | IDX_W (5) | Exception number of the request |
| req_secure | input | 1 | Secure flag of the request |
| irq_level | input | NUM_EXT (8) | External interrupt levels |
| exc_enable | input | NUM_EXC (24) | Enable per exception number |
| exc_prio | input | NUM_EXC*PRIO_W (72) | Priority per number, number n at bits [n*PRIO_W +: PRIO_W] |
| run_prio | input | PRIO_W (3) | Current running priority |
| hf_ns_route | input | 1 | 1 lets non-secure escalations reach the non-secure HardFault |
| pend_s_o | output | NUM_EXC (24) | Secure pending vector |
| pend_ns_o | output | NUM_EXC (24) | Non-secure pending vector |
| pend_valid | output | 1 | A pending, enabled exception exists |
| pend_num | output | IDX_W (5) | Number of the selected exception |
| pend_secure | output | 1 | Bank of the selected exception |
| req_err | output | 1 | Illegal request seen in the previous cycle |
| hf_forced | output | 1 | Sticky forced-escalation status |

## Verification
The properties assume that all inputs are known and change only away from the rising edge. They also assume that interrupt levels are low while reset is held, so no edge is seen on the first cycle after reset. The stimulus changes every input on the falling edge, holds the interrupt lines low before each reset, and lowers the request and write strobes one time unit after the capturing edge. Configuration inputs change only through the same falling-edge tasks, so the selection output never moves between a capture and its comparison.

// File: rtl/bpc_pkg.sv
// Package: constants shared by the banked pending controller.
// Assumes exception numbering with external interrupts starting at 16.
package bpc_pkg;
    localparam int unsigned FIRST_EXT   = 16;
    localparam int unsigned EXC_NMI     = 2;
    localparam int unsigned EXC_HARD    = 3;
    localparam int unsigned EXC_MEM     = 4;
    localparam int unsigned EXC_PENDSV  = 14;
    localparam int unsigned EXC_SYSTICK = 15;

    localparam logic [11:0] OFS_CTRL = 12'hD04;
    localparam logic [11:0] OFS_TRIG = 12'hF00;

    localparam int unsigned B_NMI_SET  = 31;
    localparam int unsigned B_PSV_SET  = 28;
    localparam int unsigned B_PSV_CLR  = 27;
    localparam int unsigned B_TICK_SET = 26;
    localparam int unsigned B_TICK_CLR = 25;

    // True for the numbers that hold a secure and a non-secure copy.
    function automatic logic is_banked(int unsigned n);
        return (n == 3) || (n == 4) || (n == 6) || (n == 11) || (n == 14) || (n == 15);
    endfunction
endpackage

// File: rtl/bpc_reg_decode.sv
// Module: decodes control-state and software-trigger writes into set/clear masks.
// Assumes a single-cycle write strobe; produces no state of its own.
module bpc_reg_decode #(
    parameter int unsigned NUM_EXC = 24,
    parameter bit          HAS_SEC = 1'b1
) (
    input  logic               wr_en,
    input  logic [11:0]        wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               wr_secure,
    output logic [NUM_EXC-1:0] set_s,
    output logic [NUM_EXC-1:0] clr_s,
    output logic [NUM_EXC-1:0] set_ns,
    output logic [NUM_EXC-1:0] clr_ns
);
    import bpc_pkg::*;

    logic       bank_sec;
    logic [9:0] trig_num;
    logic       unused_bits;

    assign bank_sec    = HAS_SEC && wr_secure;
    assign trig_num    = {1'b0, wr_data[8:0]} + 10'(FIRST_EXT);
    assign unused_bits = ^{wr_data[30:29], wr_data[24:9]};

    // Purpose: turn one register write into per-bank set and clear masks.
    always_comb begin
        set_s  = '0;
        clr_s  = '0;
        set_ns = '0;
        clr_ns = '0;
        if (wr_en && wr_addr == OFS_CTRL) begin
            if (wr_data[B_NMI_SET]) set_ns[EXC_NMI] = 1'b1;
            if (wr_data[B_PSV_SET]) begin
                if (bank_sec) set_s[EXC_PENDSV] = 1'b1; else set_ns[EXC_PENDSV] = 1'b1;
            end else if (wr_data[B_PSV_CLR]) begin
                if (bank_sec) clr_s[EXC_PENDSV] = 1'b1; else clr_ns[EXC_PENDSV] = 1'b1;
            end
            if (wr_data[B_TICK_SET]) begin
                if (bank_sec) set_s[EXC_SYSTICK] = 1'b1; else set_ns[EXC_SYSTICK] = 1'b1;
            end else if (wr_data[B_TICK_CLR]) begin
                if (bank_sec) clr_s[EXC_SYSTICK] = 1'b1; else clr_ns[EXC_SYSTICK] = 1'b1;
            end
        end
        if (wr_en && wr_addr == OFS_TRIG) begin
            for (int n = FIRST_EXT; n < NUM_EXC; n++) begin
                if (trig_num == 10'(n)) set_ns[n] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bpc_fault_path.sv
// Module: validates fault-side requests and escalates untakeable faults.
// Assumes enable/priority are shared by both copies of a banked number.
module bpc_fault_path #(
    parameter int unsigned NUM_EXC = 24,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned IDX_W   = 5,
    parameter bit          HAS_SEC = 1'b1
) (
    input  logic                      req_valid,
    input  logic                      req_clear,
    input  logic [IDX_W-1:0]          req_num,
    input  logic                      req_secure,
    input  logic [NUM_EXC-1:0]        exc_enable,
    input  logic [NUM_EXC*PRIO_W-1:0] exc_prio,
    input  logic [PRIO_W-1:0]         run_prio,
    input  logic                      hf_ns_route,
    output logic [NUM_EXC-1:0]        set_s,
    output logic [NUM_EXC-1:0]        clr_s,
    output logic [NUM_EXC-1:0]        set_ns,
    output logic [NUM_EXC-1:0]        clr_ns,
    output logic                      bad_req,
    output logic                      escalate
);
    import bpc_pkg::*;

    int unsigned       num_u;
    logic              legal;
    logic              sync_fault;
    logic              hf_sec;
    logic              r_en;
    logic [PRIO_W-1:0] r_prio;

    // Purpose: look up enable and priority of the addressed number.
    always_comb begin
        r_en   = 1'b0;
        r_prio = '0;
        for (int n = 0; n < NUM_EXC; n++) begin
            if (req_num == IDX_W'(n)) begin
                r_en   = exc_enable[n];
                r_prio = exc_prio[n*PRIO_W +: PRIO_W];
            end
        end
    end

    // Purpose: check legality, decide escalation and build the masks.
    always_comb begin
        num_u      = 32'(req_num);
        legal      = (num_u >= EXC_NMI) && (num_u < NUM_EXC) &&
                     (!req_secure || (HAS_SEC && is_banked(num_u)));
        sync_fault = (num_u >= EXC_MEM) && (num_u < EXC_PENDSV);
        hf_sec     = HAS_SEC && (req_secure || !hf_ns_route);
        bad_req    = req_valid && !legal;
        escalate   = req_valid && legal && !req_clear && sync_fault &&
                     (!r_en || (r_prio >= run_prio));
        set_s  = '0;
        clr_s  = '0;
        set_ns = '0;
        clr_ns = '0;
        if (req_valid && legal) begin
            if (escalate) begin
                if (hf_sec) set_s[EXC_HARD] = 1'b1; else set_ns[EXC_HARD] = 1'b1;
            end else begin
                for (int n = 0; n < NUM_EXC; n++) begin
                    if (req_num == IDX_W'(n)) begin
                        if (req_clear && req_secure)  clr_s[n]  = 1'b1;
                        if (req_clear && !req_secure) clr_ns[n] = 1'b1;
                        if (!req_clear && req_secure)  set_s[n]  = 1'b1;
                        if (!req_clear && !req_secure) set_ns[n] = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/bpc_irq_edge.sv
// Module: detects rising levels on the external interrupt lines.
// Assumes lines are synchronous to clk; previous levels clear on reset.
module bpc_irq_edge #(
    parameter int unsigned NUM_EXT = 8,
    parameter int unsigned NUM_EXC = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] irq_level,
    output logic [NUM_EXC-1:0] set_ns
);
    import bpc_pkg::*;

    logic [NUM_EXT-1:0] irq_q;

    // Purpose: remember last cycle's levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_level;
    end

    assign set_ns[FIRST_EXT-1:0]       = '0;
    assign set_ns[NUM_EXC-1:FIRST_EXT] = irq_level & ~irq_q;
endmodule

// File: rtl/bpc_arbiter.sv
// Module: picks the best pending, enabled entry across both banks.
// Assumes numbers 2 and 3 are always enabled and outrank all others.
module bpc_arbiter #(
    parameter int unsigned NUM_EXC = 24,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned IDX_W   = 5
) (
    input  logic [NUM_EXC-1:0]        pend_s,
    input  logic [NUM_EXC-1:0]        pend_ns,
    input  logic [NUM_EXC-1:0]        exc_enable,
    input  logic [NUM_EXC*PRIO_W-1:0] exc_prio,
    output logic                      sel_valid,
    output logic [IDX_W-1:0]          sel_num,
    output logic                      sel_secure
);
    logic [PRIO_W:0] best;
    logic [PRIO_W:0] key;
    logic            elig;

    // Purpose: scan ascending numbers, keep the first strictly better key.
    always_comb begin
        sel_valid  = 1'b0;
        sel_num    = '0;
        sel_secure = 1'b0;
        best       = '1;
        for (int n = 0; n < NUM_EXC; n++) begin
            key  = (n <= 3) ? '0 : {1'b1, exc_prio[n*PRIO_W +: PRIO_W]};
            elig = (n <= 3) || exc_enable[n];
            if (elig && pend_s[n] && (!sel_valid || key < best)) begin
                sel_valid = 1'b1; sel_num = IDX_W'(n); sel_secure = 1'b1; best = key;
            end
            if (elig && pend_ns[n] && (!sel_valid || key < best)) begin
                sel_valid = 1'b1; sel_num = IDX_W'(n); sel_secure = 1'b0; best = key;
            end
        end
    end
endmodule

// File: rtl/bpc_pend_ctrl.sv
// Module: top of the banked pending controller; holds both pending vectors,
// the error flag and the sticky forced-escalation status.
// Assumes all request sources are synchronous to clk; set wins over clear.
module bpc_pend_ctrl #(
    parameter  int unsigned NUM_EXT = 8,
    parameter  int unsigned PRIO_W  = 3,
    parameter  bit          HAS_SEC = 1'b1,
    localparam int unsigned NUM_EXC = 16 + NUM_EXT,
    localparam int unsigned IDX_W   = $clog2(NUM_EXC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr_en,
    input  logic [11:0]               reg_wr_addr,
    input  logic [31:0]               reg_wr_data,
    input  logic                      reg_wr_secure,
    input  logic                      req_valid,
    input  logic                      req_clear,
    input  logic [IDX_W-1:0]          req_num,
    input  logic                      req_secure,
    input  logic [NUM_EXT-1:0]        irq_level,
    input  logic [NUM_EXC-1:0]        exc_enable,
    input  logic [NUM_EXC*PRIO_W-1:0] exc_prio,
    input  logic [PRIO_W-1:0]         run_prio,
    input  logic                      hf_ns_route,
    output logic [NUM_EXC-1:0]        pend_s_o,
    output logic [NUM_EXC-1:0]        pend_ns_o,
    output logic                      pend_valid,
    output logic [IDX_W-1:0]          pend_num,
    output logic                      pend_secure,
    output logic                      req_err,
    output logic                      hf_forced
);
    logic [NUM_EXC-1:0] dec_set_s, dec_clr_s, dec_set_ns, dec_clr_ns;
    logic [NUM_EXC-1:0] flt_set_s, flt_clr_s, flt_set_ns, flt_clr_ns;
    logic [NUM_EXC-1:0] irq_set_ns;
    logic [NUM_EXC-1:0] pend_s, pend_ns;
    logic               bad_req, escalate;

    bpc_reg_decode #(.NUM_EXC(NUM_EXC), .HAS_SEC(HAS_SEC)) dec_i (
        .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
        .wr_secure(reg_wr_secure), .set_s(dec_set_s), .clr_s(dec_clr_s),
        .set_ns(dec_set_ns), .clr_ns(dec_clr_ns));

    bpc_fault_path #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W), .IDX_W(IDX_W),
                     .HAS_SEC(HAS_SEC)) flt_i (
        .req_valid(req_valid), .req_clear(req_clear), .req_num(req_num),
        .req_secure(req_secure), .exc_enable(exc_enable), .exc_prio(exc_prio),
        .run_prio(run_prio), .hf_ns_route(hf_ns_route), .set_s(flt_set_s),
        .clr_s(flt_clr_s), .set_ns(flt_set_ns), .clr_ns(flt_clr_ns),
        .bad_req(bad_req), .escalate(escalate));

    bpc_irq_edge #(.NUM_EXT(NUM_EXT), .NUM_EXC(NUM_EXC)) irq_i (
        .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .set_ns(irq_set_ns));

    // Purpose: merge all sources into both pending vectors and status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_s    <= '0;
            pend_ns   <= '0;
            req_err   <= 1'b0;
            hf_forced <= 1'b0;
        end else begin
            pend_s    <= (pend_s & ~(dec_clr_s | flt_clr_s)) | dec_set_s | flt_set_s;
            pend_ns   <= (pend_ns & ~(dec_clr_ns | flt_clr_ns)) |
                         dec_set_ns | flt_set_ns | irq_set_ns;
            req_err   <= bad_req;
            hf_forced <= hf_forced | escalate;
        end
    end

    assign pend_s_o  = pend_s;
    assign pend_ns_o = pend_ns;

    bpc_arbiter #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) arb_i (
        .pend_s(pend_s), .pend_ns(pend_ns), .exc_enable(exc_enable),
        .exc_prio(exc_prio), .sel_valid(pend_valid), .sel_num(pend_num),
        .sel_secure(pend_secure));
endmodule

// File: rtl/bpc_pend_ctrl_chk.sv
// Module: property checker bound to bpc_pend_ctrl.
// Assumes inputs are known and irq levels are low while reset is held.
module bpc_pend_ctrl_chk #(
    parameter  int unsigned NUM_EXT = 8,
    parameter  bit          HAS_SEC = 1'b1,
    localparam int unsigned NUM_EXC = 16 + NUM_EXT,
    localparam int unsigned IDX_W   = $clog2(NUM_EXC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr_en,
    input logic [11:0]        reg_wr_addr,
    input logic [31:0]        reg_wr_data,
    input logic               reg_wr_secure,
    input logic [NUM_EXT-1:0] irq_level,
    input logic [NUM_EXC-1:0] pend_s,
    input logic [NUM_EXC-1:0] pend_ns,
    input logic               pend_valid,
    input logic [IDX_W-1:0]   pend_num,
    input logic               pend_secure,
    input logic               hf_forced
);
    import bpc_pkg::*;

    logic ctrl_wr;
    logic unused_bits;
    assign ctrl_wr     = reg_wr_en && (reg_wr_addr == OFS_CTRL);
    assign unused_bits = ^{reg_wr_data[30:29], reg_wr_data[25:0]};

    for (genvar n = 0; n < NUM_EXC; n++) begin : g_sec
        if (!is_banked(n)) begin : g_nb
            assert_sec_copy_banked_only_R1: assert property (
                @(posedge clk) disable iff (!rst_n) !pend_s[n]);
        end
    end

    assert_low_numbers_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_s[0] && !pend_s[1] && !pend_ns[0] && !pend_ns[1]);

    assert_nmi_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && reg_wr_data[B_NMI_SET]) |=> pend_ns[EXC_NMI]);

    assert_pendsv_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && reg_wr_data[B_PSV_SET]) |=>
        ((HAS_SEC && $past(reg_wr_secure)) ? pend_s[EXC_PENDSV] : pend_ns[EXC_PENDSV]));

    assert_tick_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && reg_wr_data[B_TICK_SET]) |=>
        ((HAS_SEC && $past(reg_wr_secure)) ? pend_s[EXC_SYSTICK] : pend_ns[EXC_SYSTICK]));

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_irq
        assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_level[i]) |=> pend_ns[FIRST_EXT + i]);
    end

    assert_forced_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hf_forced |=> hf_forced);

    assert_out_is_pending_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (pend_secure ? pend_s[pend_num] : pend_ns[pend_num]));
endmodule

bind bpc_pend_ctrl bpc_pend_ctrl_chk #(.NUM_EXT(NUM_EXT), .HAS_SEC(HAS_SEC)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_wr_secure(reg_wr_secure), .irq_level(irq_level),
    .pend_s(pend_s_o), .pend_ns(pend_ns_o), .pend_valid(pend_valid),
    .pend_num(pend_num), .pend_secure(pend_secure), .hf_forced(hf_forced));

// File: tb/bpc_pend_ctrl_tb_top.sv
// Bench: scoreboard bench for bpc_pend_ctrl. Driver tasks update a reference
// model and queue expected outputs; a monitor compares after each edge.
module bpc_pend_ctrl_tb_top;
    localparam int NE = 8;
    localparam int NX = 16 + NE;
    localparam int IW = $clog2(NX);
    localparam int PW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr_en = 1'b0;
    logic [11:0]     reg_wr_addr = '0;
    logic [31:0]     reg_wr_data = '0;
    logic            reg_wr_secure = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_clear = 1'b0;
    logic [IW-1:0]   req_num = '0;
    logic            req_secure = 1'b0;
    logic [NE-1:0]   irq_level = '0;
    logic [NX-1:0]   en = '1;
    logic [NX*PW-1:0] pr = '0;
    logic [PW-1:0]   run_prio = 3'd7;
    logic            route = 1'b0;
    logic [NX-1:0]   pend_s_o, pend_ns_o;
    logic            pend_valid, pend_secure, req_err, hf_forced;
    logic [IW-1:0]   pend_num;

    logic [NX-1:0] m_s = '0, m_ns = '0;
    logic          m_forced = 1'b0;
    int            n_chk = 0, n_bad = 0;
    bit            done = 1'b0;

    typedef struct {
        string         tag;
        logic [NX-1:0] s;
        logic [NX-1:0] ns;
        logic          v;
        int            num;
        logic          sec;
        logic          err;
        logic          forced;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    bpc_pend_ctrl #(.NUM_EXT(NE), .PRIO_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_wr_secure(reg_wr_secure),
        .req_valid(req_valid), .req_clear(req_clear), .req_num(req_num),
        .req_secure(req_secure), .irq_level(irq_level), .exc_enable(en),
        .exc_prio(pr), .run_prio(run_prio), .hf_ns_route(route),
        .pend_s_o(pend_s_o), .pend_ns_o(pend_ns_o), .pend_valid(pend_valid),
        .pend_num(pend_num), .pend_secure(pend_secure), .req_err(req_err),
        .hf_forced(hf_forced));

    // Expected selection from the ranking rule of R12.
    function automatic void model_out(output logic v, output int num, output logic sec);
        int best;
        int key;
        v = 1'b0; num = 0; sec = 1'b0; best = 99;
        for (int n = 0; n < NX; n++) begin
            if (n <= 3 || en[n]) begin
                key = (n <= 3) ? -1 : int'(pr[n*PW +: PW]);
                if (m_s[n] && (!v || key < best)) begin v = 1; num = n; sec = 1; best = key; end
                if (m_ns[n] && (!v || key < best)) begin v = 1; num = n; sec = 0; best = key; end
            end
        end
    endfunction

    task automatic push(input string tag, input logic err);
        exp_t e;
        logic v;
        int num;
        logic sec;
        model_out(v, num, sec);
        e.tag = tag; e.s = m_s; e.ns = m_ns; e.v = v; e.num = num;
        e.sec = sec; e.err = err; e.forced = m_forced;
        sb_q.push_back(e);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic sec,
                      input string tag);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d; reg_wr_secure = sec;
        @(posedge clk); #1;
        reg_wr_en = 1'b0; reg_wr_data = '0;
        push(tag, 1'b0);
    endtask

    task automatic rq(input logic clr, input int num, input logic sec,
                      input string tag, input logic err);
        @(negedge clk);
        req_valid = 1'b1; req_clear = clr; req_num = IW'(num); req_secure = sec;
        @(posedge clk); #1;
        req_valid = 1'b0;
        push(tag, err);
    endtask

    task automatic set_en(input int n, input logic v, input string tag);
        @(negedge clk); en[n] = v;
        @(posedge clk); #1; push(tag, 1'b0);
    endtask

    task automatic set_pr(input int n, input int v, input string tag);
        @(negedge clk); pr[n*PW +: PW] = PW'(v);
        @(posedge clk); #1; push(tag, 1'b0);
    endtask

    task automatic set_irq(input int i, input logic v, input string tag);
        @(negedge clk); irq_level[i] = v;
        @(posedge clk); #1; push(tag, 1'b0);
    endtask

    task automatic set_route(input logic v, input string tag);
        @(negedge clk); route = v;
        @(posedge clk); #1; push(tag, 1'b0);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk); rst_n = 1'b0;
        m_s = '0; m_ns = '0; m_forced = 1'b0;
        @(posedge clk); #1; push(tag, 1'b0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    // Monitor: pop one expected item per edge and compare all outputs.
    always @(posedge clk) begin : mon
        exp_t e;
        #3;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_chk++;
            if (pend_s_o !== e.s || pend_ns_o !== e.ns || pend_valid !== e.v ||
                (e.v && (int'(pend_num) != e.num || pend_secure !== e.sec)) ||
                req_err !== e.err || hf_forced !== e.forced) begin
                n_bad++;
                $display("FAIL %s: got s=%h ns=%h v=%b num=%0d sec=%b err=%b forced=%b, expected s=%h ns=%h v=%b num=%0d sec=%b err=%b forced=%b",
                         e.tag, pend_s_o, pend_ns_o, pend_valid, pend_num, pend_secure,
                         req_err, hf_forced, e.s, e.ns, e.v, e.num, e.sec, e.err, e.forced);
            end
        end
    end

    initial begin : main
        for (int n = 0; n < NX; n++) pr[n*PW +: PW] = 3'd4;
        repeat (3) @(posedge clk);
        #1; push("R11 reset state", 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // R3: NMI always into the non-secure copy
        m_ns[2] = 1; wr(12'hD04, 32'h8000_0000, 1'b1, "R3 NMI pend");
        m_ns[2] = 0; rq(1'b1, 2, 1'b0, "R10 clear NMI", 1'b0);
        // R4: set wins over clear, bank from attribute
        m_s[14] = 1; wr(12'hD04, 32'h1800_0000, 1'b1, "R4 PendSV set beats clear");
        m_s[14] = 0; wr(12'hD04, 32'h0800_0000, 1'b1, "R4 PendSV secure clear");
        m_ns[14] = 1; wr(12'hD04, 32'h1000_0000, 1'b0, "R4 PendSV non-secure set");
        // R5
        m_s[15] = 1; wr(12'hD04, 32'h0600_0000, 1'b1, "R5 SysTick set beats clear");
        m_s[15] = 0; wr(12'hD04, 32'h0200_0000, 1'b1, "R5 SysTick clear");
        // R6
        m_ns[19] = 1; wr(12'hF00, 32'h0000_0003, 1'b0, "R6 trigger 19");
        wr(12'hF00, 32'h0000_0008, 1'b0, "R6 trigger 24 ignored");
        wr(12'hF00, 32'h0000_01FF, 1'b0, "R6 trigger 527 ignored");
        m_ns[23] = 1; wr(12'hF00, 32'h0000_0007, 1'b0, "R6 trigger last");
        // R1 / R2
        rq(1'b0, 5, 1'b1, "R1 secure non-banked dropped", 1'b1);
        m_ns[5] = 1; rq(1'b0, 5, 1'b0, "R1 non-secure copy set", 1'b0);
        m_s[11] = 1; rq(1'b0, 11, 1'b1, "R1 secure banked set", 1'b0);
        rq(1'b0, 1, 1'b0, "R2 number 1 rejected", 1'b1);
        rq(1'b1, 0, 1'b0, "R2 number 0 rejected", 1'b1);
        rq(1'b0, 25, 1'b0, "R2 number 25 rejected", 1'b1);
        // R7
        m_ns[18] = 1; set_irq(2, 1'b1, "R7 rising line pends");
        m_ns[18] = 0; rq(1'b1, 18, 1'b0, "R7 clear while high", 1'b0);
        set_irq(2, 1'b1, "R7 held high no repend");
        set_irq(2, 1'b0, "R7 line low");
        m_ns[18] = 1; set_irq(2, 1'b1, "R7 second rise pends");
        set_irq(2, 1'b0, "R7 line low again");
        // R10
        rq(1'b1, 20, 1'b0, "R10 clear of idle entry", 1'b0);
        rq(1'b1, 11, 1'b0, "R10 clear other bank only", 1'b0);
        // R8 / R9
        set_en(6, 1'b0, "R8 disable 6");
        m_s[3] = 1; m_forced = 1; rq(1'b0, 6, 1'b1, "R8 R9 disabled escalates secure", 1'b0);
        m_s[3] = 0; rq(1'b1, 3, 1'b1, "R10 clear secure HardFault", 1'b0);
        set_route(1'b1, "R9 route set");
        set_en(12, 1'b0, "R8 disable 12");
        m_ns[3] = 1; rq(1'b0, 12, 1'b0, "R9 non-secure HardFault", 1'b0);
        m_ns[3] = 0; rq(1'b1, 3, 1'b0, "R10 clear non-secure HardFault", 1'b0);
        set_route(1'b0, "R9 route clear");
        set_pr(4, 7, "R8 prio 4 to 7");
        m_s[3] = 1; rq(1'b0, 4, 1'b0, "R8 R9 prio equal escalates secure", 1'b0);
        set_pr(13, 6, "R8 prio 13 to 6");
        m_ns[13] = 1; rq(1'b0, 13, 1'b0, "R8 prio below running no escalation", 1'b0);
        // R11 mid-run reset
        do_reset("R11 reset clears all");
        // R12 ranking
        m_ns[20] = 1; rq(1'b0, 20, 1'b0, "R12 single pending", 1'b0);
        m_ns[17] = 1; rq(1'b0, 17, 1'b0, "R12 lower number wins", 1'b0);
        set_pr(20, 2, "R12 better priority wins");
        set_en(20, 1'b0, "R12 disabled skipped");
        set_pr(15, 0, "R12 prio 15 to 0");
        m_ns[15] = 1; wr(12'hD04, 32'h0400_0000, 1'b0, "R12 non-secure 15");
        m_s[15] = 1; wr(12'hD04, 32'h0400_0000, 1'b1, "R12 secure before non-secure");
        m_s[15] = 0; wr(12'hD04, 32'h0200_0000, 1'b1, "R12 secure copy cleared");
        m_ns[2] = 1; wr(12'hD04, 32'h8000_0000, 1'b0, "R12 NMI outranks all");

        wait (sb_q.size() == 0);
        @(posedge clk); #5;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no completion, expected end of sequence");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule